// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the state changes a processor core makes when it takes a trap. In the cycle a trap is requested it receives the cause code, an interrupt flag, the PC of the trapping instruction, the faulting address, the current privilege level and the current global interrupt enables. From these it decides whether supervisor or machine mode handles the trap. At the next clock edge it commits the cause, exception PC and trap value of that mode, pushes the status stack of that mode, switches privilege and produces the handler address.

The two delegation masks and the two trap-vector words arrive as plain inputs from the surrounding control-register file. The block keeps the per-mode trap registers and the stacked status bits itself and presents them on its outputs. An environment call is requested with cause 8 whatever mode issued it. The block rewrites that code by the issuing mode before it reads the delegation mask.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege output is machine (3). The handler address, all cause, EPC and trap-value outputs and all stack bits are zero, and the taken flag is low.
- R2: A trap is handled in supervisor mode only when the current privilege is user (0) or supervisor (1) and the delegation bit indexed by the final cause code is set. The interrupt mask is used for interrupts and the exception mask for exceptions. Every other trap, including any trap raised from privilege 2 or 3, is handled in machine mode.
- R3: The cause register of the handling mode receives the 5-bit final code in bits 4:0, with bit 31 set for an interrupt and clear for an exception.
- R4: The EPC register of the handling mode receives the trap PC, and the privilege output becomes 1 for supervisor handling or 3 for machine handling.
- R5: The handler address is the handling mode's vector word with bits 1:0 cleared. Code times 4 is added only when the trap is an interrupt and vector bits 1:0 equal 01.
- R6: The trap value of the handling mode receives the faulting address for exceptions with codes 0, 1, 4, 5, 6, 7, 12, 13 or 15. It receives zero for every other exception and for every interrupt.
- R7: An exception requested with code 8 becomes code 8 from user, 9 from supervisor and 11 from privilege 2 or 3. The rewritten code is used for both delegation and the cause register.
- R8: On entry the handling mode's previous-enable bit takes its current enable input and its enable bit is cleared. Its previous-privilege field takes the current privilege: two bits for machine, bit 0 for supervisor.
- R9: The registers and stack bits of the mode not handling the trap keep their values. When no trap is requested, no register or output changes.
- R10: The taken flag is high in exactly the cycle after a trap request. All updates of one trap appear together at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trapValid | input | 1 | Trap requested this cycle |
| trapIsIrq | input | 1 | 1 = interrupt, 0 = exception |
| trapCause | input | 5 | Requested cause code |
| trapPc | input | 32 | PC of the trapping instruction |
| trapAddr | input | 32 | Faulting address |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| curMie | input | 1 | Current machine interrupt enable |
| curSie | input | 1 | Current supervisor interrupt enable |
| midelegIn | input | 32 | Interrupt delegation mask |
| medelegIn | input | 32 | Exception delegation mask |
| mtvecIn | input | 32 | Machine vector word (base plus mode bits 1:0) |
| stvecIn | input | 32 | Supervisor vector word (base plus mode bits 1:0) |
| takenOut | output | 1 | Trap committed at the last edge |
| privOut | output | 2 | Privilege after the last trap |
| nextPcOut | output | 32 | Handler address |
| mcauseOut | output | 32 | Machine cause |
| mepcOut | output | 32 | Machine exception PC |
| mtvalOut | output | 32 | Machine trap value |
| scauseOut | output | 32 | Supervisor cause |
| sepcOut | output | 32 | Supervisor exception PC |
| stvalOut | output | 32 | Supervisor trap value |
| mieOut | output | 1 | Machine enable bit |
| mpieOut | output | 1 | Machine previous enable |
| mppOut | output | 2 | Machine previous privilege |
| sieOut | output | 1 | Supervisor enable bit |
| spieOut | output | 1 | Supervisor previous enable |
| sppOut | output | 1 | Supervisor previous privilege |

## Verification
The functions that meet in one cycle are the environment-call rewrite and the delegation decision. The rewritten code, not the requested one, must select the mask bit. The bench provokes this by setting only bit 8 of the exception mask. An environment call from user must then land in supervisor with code 8, and one from supervisor must land in machine with code 9. A second overlap occurs when an interrupt code also belongs to the address-fault list. Here the trap value must stay zero while the vectored offset still applies, and the bench judges this against its behavioural model on every clock.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CAUSE_W = 5;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } privT;

  // Codes for the environment call, by issuing mode
  localparam logic [CAUSE_W-1:0] ECALL_FROM_U = 5'd8;
  localparam logic [CAUSE_W-1:0] ECALL_FROM_S = 5'd9;
  localparam logic [CAUSE_W-1:0] ECALL_FROM_M = 5'd11;

  // Exception codes that carry an address: misaligned, access and page faults
  localparam logic [31:0] ADDR_FAULT_MASK = 32'h0000_B0F3;

  // Index of each mode's register bank
  localparam int BANK_S = 0;
  localparam int BANK_M = 1;
  localparam int BANKS  = 2;

  typedef struct packed {
    logic                commitS;
    logic                commitM;
    logic                isIrq;
    logic                keepAddr;
    logic [CAUSE_W-1:0]  cause;
  } trapStrobeT;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    midelegIn,
  input  logic [XLEN-1:0]    medelegIn,
  output trapStrobeT         strobe
);
  logic [CAUSE_W-1:0] finalCause;
  logic               delegBit;
  logic               lowPriv;
  logic               toSuper;

  // Environment calls are renamed by the mode that issued them
  always_comb begin
    finalCause = trapCause;
    if (!trapIsIrq && trapCause == ECALL_FROM_U) begin
      unique case (curPriv)
        PRIV_USER:  finalCause = ECALL_FROM_U;
        PRIV_SUPER: finalCause = ECALL_FROM_S;
        default:    finalCause = ECALL_FROM_M;
      endcase
    end
  end

  assign delegBit = trapIsIrq ? midelegIn[finalCause] : medelegIn[finalCause];
  assign lowPriv  = (curPriv == PRIV_USER) || (curPriv == PRIV_SUPER);
  assign toSuper  = lowPriv && delegBit;

  always_comb begin
    strobe.commitS  = trapValid && toSuper;
    strobe.commitM  = trapValid && !toSuper;
    strobe.isIrq    = trapIsIrq;
    strobe.keepAddr = !trapIsIrq && ADDR_FAULT_MASK[finalCause];
    strobe.cause    = finalCause;
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobeT      strobe,
  input  logic [XLEN-1:0] trapPc,
  input  logic [XLEN-1:0] trapAddr,
  input  logic [1:0]      curPriv,
  input  logic            curMie,
  input  logic            curSie,
  input  logic [XLEN-1:0] mtvecIn,
  input  logic [XLEN-1:0] stvecIn,
  output logic            takenOut,
  output logic [1:0]      privOut,
  output logic [XLEN-1:0] nextPcOut,
  output logic [XLEN-1:0] causeBank [BANKS],
  output logic [XLEN-1:0] epcBank   [BANKS],
  output logic [XLEN-1:0] tvalBank  [BANKS],
  output logic            mieOut,
  output logic            mpieOut,
  output logic [1:0]      mppOut,
  output logic            sieOut,
  output logic            spieOut,
  output logic            sppOut
);
  localparam int PAD_CAUSE  = XLEN - 1 - CAUSE_W;
  localparam int PAD_OFFSET = XLEN - CAUSE_W - 2;

  logic [XLEN-1:0] selVec;
  logic [XLEN-1:0] vecBase;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] causeWord;
  logic [XLEN-1:0] tvalWord;
  logic            anyCommit;

  assign anyCommit = strobe.commitS || strobe.commitM;
  assign selVec    = strobe.commitS ? stvecIn : mtvecIn;
  assign vecBase   = {selVec[XLEN-1:2], 2'b00};
  assign vecOffset = (strobe.isIrq && selVec[1:0] == 2'b01)
                     ? {{PAD_OFFSET{1'b0}}, strobe.cause, 2'b00}
                     : '0;
  assign causeWord = {strobe.isIrq, {PAD_CAUSE{1'b0}}, strobe.cause};
  assign tvalWord  = strobe.keepAddr ? trapAddr : '0;

  // One bank per handling mode
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bankCommit;
    assign bankCommit = (b == BANK_M) ? strobe.commitM : strobe.commitS;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        causeBank[b] <= '0;
        epcBank[b]   <= '0;
        tvalBank[b]  <= '0;
      end else if (bankCommit) begin
        causeBank[b] <= causeWord;
        epcBank[b]   <= trapPc;
        tvalBank[b]  <= tvalWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takenOut  <= 1'b0;
      privOut   <= PRIV_MACH;
      nextPcOut <= '0;
    end else begin
      takenOut <= anyCommit;
      if (anyCommit) begin
        privOut   <= strobe.commitS ? PRIV_SUPER : PRIV_MACH;
        nextPcOut <= vecBase + vecOffset;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mieOut  <= 1'b0;
      mpieOut <= 1'b0;
      mppOut  <= 2'b00;
    end else if (strobe.commitM) begin
      mpieOut <= curMie;
      mieOut  <= 1'b0;
      mppOut  <= curPriv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sieOut  <= 1'b0;
      spieOut <= 1'b0;
      sppOut  <= 1'b0;
    end else if (strobe.commitS) begin
      spieOut <= curSie;
      sieOut  <= 1'b0;
      sppOut  <= curPriv[0];
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [XLEN-1:0]    trapAddr,
  input  logic [1:0]         curPriv,
  input  logic               curMie,
  input  logic               curSie,
  input  logic [XLEN-1:0]    midelegIn,
  input  logic [XLEN-1:0]    medelegIn,
  input  logic [XLEN-1:0]    mtvecIn,
  input  logic [XLEN-1:0]    stvecIn,
  output logic               takenOut,
  output logic [1:0]         privOut,
  output logic [XLEN-1:0]    nextPcOut,
  output logic [XLEN-1:0]    mcauseOut,
  output logic [XLEN-1:0]    mepcOut,
  output logic [XLEN-1:0]    mtvalOut,
  output logic [XLEN-1:0]    scauseOut,
  output logic [XLEN-1:0]    sepcOut,
  output logic [XLEN-1:0]    stvalOut,
  output logic               mieOut,
  output logic               mpieOut,
  output logic [1:0]         mppOut,
  output logic               sieOut,
  output logic               spieOut,
  output logic               sppOut
);
  trapStrobeT      strobe;
  logic [XLEN-1:0] causeBank [BANKS];
  logic [XLEN-1:0] epcBank   [BANKS];
  logic [XLEN-1:0] tvalBank  [BANKS];

  trap_ctrl #(.XLEN(XLEN)) u_ctrl (
    .trapValid (trapValid),
    .trapIsIrq (trapIsIrq),
    .trapCause (trapCause),
    .curPriv   (curPriv),
    .midelegIn (midelegIn),
    .medelegIn (medelegIn),
    .strobe    (strobe)
  );

  trap_datapath #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .trapPc    (trapPc),
    .trapAddr  (trapAddr),
    .curPriv   (curPriv),
    .curMie    (curMie),
    .curSie    (curSie),
    .mtvecIn   (mtvecIn),
    .stvecIn   (stvecIn),
    .takenOut  (takenOut),
    .privOut   (privOut),
    .nextPcOut (nextPcOut),
    .causeBank (causeBank),
    .epcBank   (epcBank),
    .tvalBank  (tvalBank),
    .mieOut    (mieOut),
    .mpieOut   (mpieOut),
    .mppOut    (mppOut),
    .sieOut    (sieOut),
    .spieOut   (spieOut),
    .sppOut    (sppOut)
  );

  assign mcauseOut = causeBank[BANK_M];
  assign mepcOut   = epcBank[BANK_M];
  assign mtvalOut  = tvalBank[BANK_M];
  assign scauseOut = causeBank[BANK_S];
  assign sepcOut   = epcBank[BANK_S];
  assign stvalOut  = tvalBank[BANK_S];
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic            trapIsIrq,
  input logic [1:0]      curPriv,
  input logic [XLEN-1:0] trapPc,
  input logic            takenOut,
  input logic [1:0]      privOut,
  input logic [XLEN-1:0] nextPcOut,
  input logic [XLEN-1:0] mcauseOut,
  input logic [XLEN-1:0] mepcOut,
  input logic [XLEN-1:0] scauseOut,
  input logic [XLEN-1:0] sepcOut,
  input logic            mieOut,
  input logic            sieOut
);
  AST_HIGH_PRIV_STAYS_MACHINE: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv[1]) |=> (privOut == 2'd3)); // R2

  AST_IRQ_MSB_SET: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapIsIrq) |=> (privOut == 2'd3 ? mcauseOut[XLEN-1] : scauseOut[XLEN-1])); // R3

  AST_EXC_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !trapIsIrq) |=> !(privOut == 2'd3 ? mcauseOut[XLEN-1] : scauseOut[XLEN-1])); // R3

  AST_TARGET_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == 2'd1 || privOut == 2'd3)); // R4

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> ((privOut == 2'd3 ? mepcOut : sepcOut) == $past(trapPc))); // R4

  AST_EXC_NO_OFFSET_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !trapIsIrq) |=> (nextPcOut[1:0] == 2'b00)); // R5

  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privOut == 2'd3 ? !mieOut : !sieOut)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> ($stable(privOut) && $stable(mepcOut) && $stable(sepcOut) && $stable(nextPcOut))); // R9

  AST_TAKEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> takenOut); // R10

  AST_TAKEN_ONLY_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !takenOut); // R10
endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .trapValid (trapValid),
  .trapIsIrq (trapIsIrq),
  .curPriv   (curPriv),
  .trapPc    (trapPc),
  .takenOut  (takenOut),
  .privOut   (privOut),
  .nextPcOut (nextPcOut),
  .mcauseOut (mcauseOut),
  .mepcOut   (mepcOut),
  .scauseOut (scauseOut),
  .sepcOut   (sepcOut),
  .mieOut    (mieOut),
  .sieOut    (sieOut)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapValid = 1'b0;
  logic        trapIsIrq = 1'b0;
  logic [4:0]  trapCause = '0;
  logic [31:0] trapPc = '0;
  logic [31:0] trapAddr = '0;
  logic [1:0]  curPriv = 2'd3;
  logic        curMie = 1'b0;
  logic        curSie = 1'b0;
  logic [31:0] midelegIn = '0;
  logic [31:0] medelegIn = '0;
  logic [31:0] mtvecIn = '0;
  logic [31:0] stvecIn = '0;

  logic        takenOut;
  logic [1:0]  privOut;
  logic [31:0] nextPcOut, mcauseOut, mepcOut, mtvalOut, scauseOut, sepcOut, stvalOut;
  logic        mieOut, mpieOut, sieOut, spieOut, sppOut;
  logic [1:0]  mppOut;

  int testCount = 0;
  int failCount = 0;

  trap_entry_unit dut (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapIsIrq(trapIsIrq),
    .trapCause(trapCause), .trapPc(trapPc), .trapAddr(trapAddr),
    .curPriv(curPriv), .curMie(curMie), .curSie(curSie),
    .midelegIn(midelegIn), .medelegIn(medelegIn),
    .mtvecIn(mtvecIn), .stvecIn(stvecIn),
    .takenOut(takenOut), .privOut(privOut), .nextPcOut(nextPcOut),
    .mcauseOut(mcauseOut), .mepcOut(mepcOut), .mtvalOut(mtvalOut),
    .scauseOut(scauseOut), .sepcOut(sepcOut), .stvalOut(stvalOut),
    .mieOut(mieOut), .mpieOut(mpieOut), .mppOut(mppOut),
    .sieOut(sieOut), .spieOut(spieOut), .sppOut(sppOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int addrCodes[$] = '{0, 1, 4, 5, 6, 7, 12, 13, 15};
  bit        eTaken, eMie, eMpie, eSie, eSpie, eSpp;
  int        ePriv, eMpp;
  bit [31:0] eNextPc, eMcause, eMepc, eMtval, eScause, eSepc, eStval;

  function automatic bit hasAddr(int code);
    foreach (addrCodes[i]) if (addrCodes[i] == code) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eTaken <= 0; ePriv <= 3; eNextPc <= 0;
      eMcause <= 0; eMepc <= 0; eMtval <= 0;
      eScause <= 0; eSepc <= 0; eStval <= 0;
      eMie <= 0; eMpie <= 0; eMpp <= 0; eSie <= 0; eSpie <= 0; eSpp <= 0;
    end else begin
      int        code;
      bit        toS;
      bit [31:0] vec, causeVal, tvalVal, target;
      eTaken <= trapValid;
      if (trapValid) begin
        code = int'(trapCause);
        if (!trapIsIrq && code == 8)
          code = (curPriv == 0) ? 8 : (curPriv == 1) ? 9 : 11;
        toS = (curPriv < 2) && (trapIsIrq ? midelegIn[code] : medelegIn[code]);
        vec = toS ? stvecIn : mtvecIn;
        target = (vec / 4) * 4;
        if (trapIsIrq && (vec % 4) == 1) target = target + 32'(code * 4);
        causeVal = 32'(code) + (trapIsIrq ? 32'h8000_0000 : 32'h0);
        tvalVal = (!trapIsIrq && hasAddr(code)) ? trapAddr : 32'h0;
        eNextPc <= target;
        if (toS) begin
          ePriv <= 1; eScause <= causeVal; eSepc <= trapPc; eStval <= tvalVal;
          eSpie <= curSie; eSie <= 0; eSpp <= (curPriv == 1);
        end else begin
          ePriv <= 3; eMcause <= causeVal; eMepc <= trapPc; eMtval <= tvalVal;
          eMpie <= curMie; eMie <= 0; eMpp <= int'(curPriv);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    chk("R10 taken",       32'(takenOut),  32'(eTaken));
    chk("R4 priv",         32'(privOut),   32'(ePriv));
    chk("R5 nextPc",       nextPcOut,      eNextPc);
    chk("R3 mcause",       mcauseOut,      eMcause);
    chk("R3 scause",       scauseOut,      eScause);
    chk("R4 mepc",         mepcOut,        eMepc);
    chk("R4 sepc",         sepcOut,        eSepc);
    chk("R6 mtval",        mtvalOut,       eMtval);
    chk("R6 stval",        stvalOut,       eStval);
    chk("R8 machine stack", {27'd0, mieOut, mpieOut, mppOut, 1'b0},
                            {27'd0, eMie, eMpie, 2'(eMpp), 1'b0});
    chk("R8 super stack",  {29'd0, sieOut, spieOut, sppOut}, {29'd0, eSie, eSpie, eSpp});
  end

  task automatic doTrap(bit irq, int code, int priv, logic [31:0] pc, logic [31:0] addr);
    trapValid = 1; trapIsIrq = irq; trapCause = 5'(code);
    curPriv = 2'(priv); trapPc = pc; trapAddr = addr;
    @(posedge clk); #1;
    trapValid = 0;
  endtask

  task automatic runAll();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset priv",   32'(privOut), 32'd3);
    chk("R1 reset cause",  mcauseOut,    32'd0);
    chk("R1 reset nextPc", nextPcOut,    32'd0);
    chk("R1 reset taken",  32'(takenOut), 32'd0);
    rstN = 1;
    @(posedge clk); #1;

    // Environment call from user, only code 8 delegated
    medelegIn = 32'h0000_0100; midelegIn = 0;
    stvecIn = 32'h8000_0100; mtvecIn = 32'h8000_0000;
    doTrap(0, 8, 0, 32'h1000, 32'hDEAD);
    chk("R2 ecall U delegated", 32'(privOut), 32'd1);
    chk("R7 ecall U code",      scauseOut,    32'd8);
    chk("R4 sepc",              sepcOut,      32'h1000);
    chk("R6 ecall no tval",     stvalOut,     32'd0);
    chk("R5 super base",        nextPcOut,    32'h8000_0100);
    chk("R10 taken pulse",      32'(takenOut), 32'd1);

    // Environment call from supervisor: rewritten to 9, not delegated
    doTrap(0, 8, 1, 32'h2000, 32'h0);
    chk("R2 ecall S to machine", 32'(privOut), 32'd3);
    chk("R7 ecall S code",       mcauseOut,    32'd9);
    chk("R5 machine base",       nextPcOut,    32'h8000_0000);
    chk("R9 sepc kept",          sepcOut,      32'h1000);

    // Machine never delegates
    medelegIn = 32'hFFFF_FFFF;
    doTrap(0, 8, 3, 32'h3000, 32'h0);
    chk("R7 ecall M code",       mcauseOut,    32'd11);
    chk("R2 machine stays",      32'(privOut), 32'd3);

    // Vectored interrupt into supervisor
    medelegIn = 0; midelegIn = 32'h0000_0080; stvecIn = 32'h0000_1001; curSie = 1;
    doTrap(1, 7, 1, 32'h4000, 32'h55);
    chk("R2 irq delegated",     32'(privOut), 32'd1);
    chk("R3 irq cause",         scauseOut,    32'h8000_0007);
    chk("R5 vectored offset",   nextPcOut,    32'h0000_101C);
    chk("R6 irq no tval",       stvalOut,     32'd0);
    chk("R8 spie",              32'(spieOut), 32'd1);
    chk("R8 sie cleared",       32'(sieOut),  32'd0);
    chk("R8 spp",               32'(sppOut),  32'd1);

    // Same code as exception: exception mask clear, so machine
    mtvecIn = 32'h0000_2001; curMie = 1;
    doTrap(0, 7, 0, 32'h5000, 32'hCAFE_0000);
    chk("R2 exception mask used", 32'(privOut), 32'd3);
    chk("R6 store fault tval",    mtvalOut,     32'hCAFE_0000);
    chk("R5 no offset for exc",   nextPcOut,    32'h0000_2000);
    chk("R8 mpp from user",       32'(mppOut),  32'd0);
    chk("R8 mpie",                32'(mpieOut), 32'd1);
    chk("R3 exc cause",           mcauseOut,    32'd7);

    // Illegal instruction: no address
    doTrap(0, 2, 0, 32'h6000, 32'h77);
    chk("R6 non-address tval", mtvalOut, 32'd0);

    // Interrupt whose code is in the address list, vector mode 3
    midelegIn = 32'hFFFF_FFFF; stvecIn = 32'h0000_3003;
    doTrap(1, 5, 0, 32'h7000, 32'h1234);
    chk("R5 mode 3 no offset", nextPcOut, 32'h0000_3000);
    chk("R6 irq code 5 tval",  stvalOut,  32'd0);
    chk("R8 spp from user",    32'(sppOut), 32'd0);

    // Idle: changing inputs must leave everything alone
    trapPc = 32'hFFFF_FFF0; curPriv = 0; mtvecIn = 32'h9999_0000;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 idle no taken", 32'(takenOut), 32'd0);
    chk("R9 idle mepc",      mepcOut,       32'h0000_6000);
    chk("R9 idle sepc",      sepcOut,       32'h0000_7000);
    chk("R9 idle priv",      32'(privOut),  32'd1);

    // Random traffic checked against the model each clock
    for (int n = 0; n < 800; n++) begin
      trapValid = $urandom_range(0, 1) == 1;
      trapIsIrq = $urandom_range(0, 1) == 1;
      trapCause = 5'($urandom_range(0, 15));
      trapPc = $urandom; trapAddr = $urandom;
      curPriv = 2'($urandom_range(0, 3));
      curMie = $urandom_range(0, 1) == 1; curSie = $urandom_range(0, 1) == 1;
      midelegIn = $urandom; medelegIn = $urandom;
      mtvecIn = $urandom; stvecIn = $urandom;
      @(posedge clk); #1;
    end
    trapValid = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        failCount++;
        $display("FAIL watchdog expired");
      end
    join_any
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule